// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic datapath of a small 8-bit microcontroller core. Each accepted operation takes a destination byte, a source or immediate byte, an extra high byte for word operations, the current eight status bits and a 4-bit operation code. It returns a 16-bit result and the next status bits through one output register. The core chains status by feeding the `flags_o` of one operation back as `flags_i` of the next. Compares use the subtract codes, and the caller drops the result.

Operands enter through a valid/ready handshake and results leave through another. An operation is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid_o` is high and `out_ready_i` is low, the output holds its value and no new operation is taken. The result appears one edge after acceptance.

Status byte layout, from bit 0 upward: C, Z, N, V, S, H, T, I. Operation codes: 0 ADD, 1 ADC, 2 SUB/compare, 3 SBC/compare-with-carry, 4 AND, 5 OR, 6 EOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 SWAP, 12 ASR, 13 LSR, 14 ROR, 15 WORD.

Top module: `alu8_core`

## Requirements
- R1: After reset, `out_valid_o` is 0, `res_o` is 0x0000, `flags_o` is 0x00 and `in_ready_o` is 1. For byte operations (codes 0 to 14), `res_o[15:8]` is 0.
- R2: ADD (0) computes dst+src and ADC (1) computes dst+src+C. With carry vector cv=(d&s)|(s&~r)|(~r&d), H=cv[3] and C=cv[7], and V=bit 7 of (d&s&~r)|(~d&~s&r). Z is set when the result is zero.
- R3: SUB (2) computes dst-src. With borrow vector bv=(~d&s)|(s&r)|(r&~d), H=bv[3] and C=bv[7], and V=bit 7 of (d&~s&~r)|(~d&s&r). Z is set when the result is zero.
- R4: SBC (3) computes dst-src-C and sets H, C and V as in R3. Z is cleared when the result is nonzero and otherwise keeps its incoming value, so a zero Z in stays zero.
- R5: AND (4), OR (5) and EOR (6) clear V and keep C and H. COM (7) yields 0xFF-dst, clears V, sets C and keeps H.
- R6: NEG (8) yields 0-dst, with C set for a nonzero result, V set for a result of 0x80, and H equal to bit 3 of (result | dst).
- R7: INC (9) and DEC (10) add or subtract one. V is set on a result of 0x80 for INC and 0x7F for DEC. C and H are kept.
- R8: ASR (12) keeps bit 7, LSR (13) shifts in 0 and ROR (14) shifts the incoming C into bit 7. For all three, C takes dst bit 0, LSR forces N to 0, V=N^C, and H is kept.
- R9: WORD (15) works on {hi,dst} with the immediate src[5:0]. src[6]=0 adds and src[6]=1 subtracts. For add, V=bit 15 of (~old&r) and C=bit 15 of (~r&old). For subtract, V=bit 15 of (old&~r) and C=bit 15 of (r&~old). Z and N are judged on all 16 bits, and H is kept.
- R10: SWAP (11) exchanges the nibbles of dst and leaves all eight flags unchanged. No operation alters T (bit 6) or I (bit 7).
- R11: For every operation except SWAP, N is the result MSB and S equals N XOR V.
- R12: `in_ready_o` equals `!out_valid_o || out_ready_i`. While `out_valid_o` is high and `out_ready_i` is low, `res_o` and `flags_o` hold and `out_valid_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken |
| op_i | input | 4 | Operation code |
| dst_i | input | 8 | Destination operand, low byte for word operations |
| src_i | input | 8 | Source operand or immediate |
| hi_i | input | 8 | High byte for word operations |
| flags_i | input | 8 | Current status bits |
| out_valid_o | output | 1 | Result register holds an unread result |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 16 | Result, upper byte used by word operations |
| flags_o | output | 8 | Next status bits |

## Verification
On every cycle, the assertions check the handshake law and holding under back-pressure, that T and I pass through, that S equals N XOR V after non-SWAP operations, and that the carry-chained subtract never raises Z. The exact carry, half-carry and overflow values per operation, the results and the word-operation corners are shown only by the bench's scenarios. The bench compares these against its own reference over random and directed operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int WW = 2 * DW;
  localparam int FW = 8;
  localparam int HB = DW / 2 - 1;
  localparam int IMM_W = 6;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int F_T = 6;
  localparam int F_I = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_EOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SWAP = 4'd11,
    OP_ASR  = 4'd12,
    OP_LSR  = 4'd13,
    OP_ROR  = 4'd14,
    OP_WORD = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [WW-1:0] res;
    logic [FW-1:0] flags;
  } alu_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sub_i,
  input  logic          chain_i,
  input  logic [FW-1:0] fl_i,
  output logic [W-1:0]  res_o,
  output logic [FW-1:0] fl_o
);
  localparam int HI = W / 2 - 1;

  logic [W-1:0] cin_w, r, cvec, ovec;
  logic         zero_r;

  always_comb begin
    cin_w = '0;
    cin_w[0] = chain_i & fl_i[F_C];
    if (sub_i) begin
      r    = a_i - b_i - cin_w;
      cvec = (~a_i & b_i) | (b_i & r) | (r & ~a_i);
      ovec = (a_i & ~b_i & ~r) | (~a_i & b_i & r);
    end else begin
      r    = a_i + b_i + cin_w;
      cvec = (a_i & b_i) | (b_i & ~r) | (~r & a_i);
      ovec = (a_i & b_i & ~r) | (~a_i & ~b_i & r);
    end
    zero_r = (r == '0);
    fl_o = fl_i;
    fl_o[F_H] = cvec[HI];
    fl_o[F_C] = cvec[W-1];
    fl_o[F_V] = ovec[W-1];
    fl_o[F_N] = r[W-1];
    // sticky zero for carry-chained subtract
    fl_o[F_Z] = (sub_i && chain_i) ? (fl_i[F_Z] & zero_r) : zero_r;
    fl_o[F_S] = fl_o[F_N] ^ fl_o[F_V];
    res_o = r;
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e       op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [FW-1:0] fl_i,
  output logic [W-1:0]  res_o,
  output logic [FW-1:0] fl_o
);
  localparam int HI = W / 2 - 1;
  localparam int HALF = W / 2;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] r;
  logic         upd_zns;
  logic         shift_op;

  always_comb begin
    r        = a_i;
    fl_o     = fl_i;
    upd_zns  = 1'b1;
    shift_op = 1'b0;
    unique case (op_i)
      OP_AND: begin r = a_i & b_i; fl_o[F_V] = 1'b0; end
      OP_OR:  begin r = a_i | b_i; fl_o[F_V] = 1'b0; end
      OP_EOR: begin r = a_i ^ b_i; fl_o[F_V] = 1'b0; end
      OP_COM: begin
        r = ~a_i;
        fl_o[F_V] = 1'b0;
        fl_o[F_C] = 1'b1;
      end
      OP_NEG: begin
        r = '0 - a_i;
        fl_o[F_C] = (r != '0);
        fl_o[F_V] = (r == MIN_NEG);
        fl_o[F_H] = r[HI] | a_i[HI];
      end
      OP_INC: begin
        r = a_i + ONE;
        fl_o[F_V] = (r == MIN_NEG);
      end
      OP_DEC: begin
        r = a_i - ONE;
        fl_o[F_V] = (r == MAX_POS);
      end
      OP_SWAP: begin
        r = {a_i[HALF-1:0], a_i[W-1:HALF]};
        upd_zns = 1'b0;
      end
      OP_ASR: begin r = {a_i[W-1], a_i[W-1:1]};  shift_op = 1'b1; end
      OP_LSR: begin r = {1'b0, a_i[W-1:1]};      shift_op = 1'b1; end
      OP_ROR: begin r = {fl_i[F_C], a_i[W-1:1]}; shift_op = 1'b1; end
      default: begin r = a_i; upd_zns = 1'b0; end
    endcase
    if (upd_zns) begin
      fl_o[F_Z] = (r == '0);
      fl_o[F_N] = r[W-1];
      if (shift_op) begin
        fl_o[F_C] = a_i[0];
        fl_o[F_V] = fl_o[F_N] ^ fl_o[F_C];
      end
      fl_o[F_S] = fl_o[F_N] ^ fl_o[F_V];
    end
    res_o = r;
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word
  import alu8_pkg::*;
#(
  parameter int W  = WW,
  parameter int KW = IMM_W
) (
  input  logic [W-1:0]  old_i,
  input  logic [KW-1:0] k_i,
  input  logic          sub_i,
  input  logic [FW-1:0] fl_i,
  output logic [W-1:0]  res_o,
  output logic [FW-1:0] fl_o
);
  logic [W-1:0] kx, r;

  always_comb begin
    kx = W'(k_i);
    fl_o = fl_i;
    if (sub_i) begin
      r = old_i - kx;
      fl_o[F_V] = old_i[W-1] & ~r[W-1];
      fl_o[F_C] = r[W-1] & ~old_i[W-1];
    end else begin
      r = old_i + kx;
      fl_o[F_V] = ~old_i[W-1] & r[W-1];
      fl_o[F_C] = ~r[W-1] & old_i[W-1];
    end
    fl_o[F_Z] = (r == '0);
    fl_o[F_N] = r[W-1];
    fl_o[F_S] = fl_o[F_N] ^ fl_o[F_V];
    res_o = r;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] hi_i,
  input  logic [FW-1:0] flags_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [WW-1:0] res_o,
  output logic [FW-1:0] flags_o
);
  alu_op_e       op;
  logic [DW-1:0] as_res, un_res;
  logic [FW-1:0] as_fl, un_fl, wd_fl;
  logic [WW-1:0] wd_res;
  alu_out_t      nxt, held;
  logic          out_v;
  logic          take;

  assign op = alu_op_e'(op_i);

  alu8_addsub #(.W(DW)) u_addsub (
    .a_i    (dst_i),
    .b_i    (src_i),
    .sub_i  (op == OP_SUB || op == OP_SBC),
    .chain_i(op == OP_ADC || op == OP_SBC),
    .fl_i   (flags_i),
    .res_o  (as_res),
    .fl_o   (as_fl)
  );

  alu8_unary #(.W(DW)) u_unary (
    .op_i (op),
    .a_i  (dst_i),
    .b_i  (src_i),
    .fl_i (flags_i),
    .res_o(un_res),
    .fl_o (un_fl)
  );

  alu8_word #(.W(WW), .KW(IMM_W)) u_word (
    .old_i(
      {hi_i, dst_i}),
    .k_i  (src_i[IMM_W-1:0]),
    .sub_i(src_i[IMM_W]),
    .fl_i (flags_i),
    .res_o(wd_res),
    .fl_o (wd_fl)
  );

  always_comb begin
    if (op == OP_WORD) begin
      nxt.res   = wd_res;
      nxt.flags = wd_fl;
    end else if (op_i <= 4'(OP_SBC)) begin
      nxt.res   = WW'(as_res);
      nxt.flags = as_fl;
    end else begin
      nxt.res   = WW'(un_res);
      nxt.flags = un_fl;
    end
  end

  assign in_ready_o = !out_v || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_v <= 1'b0;
      held  <= '0;
    end else if (take) begin
      out_v <= 1'b1;
      held  <= nxt;
    end else if (out_ready_i) begin
      out_v <= 1'b0;
    end
  end

  assign out_valid_o = out_v;
  assign res_o       = held.res;
  assign flags_o     = held.flags;

  // R12
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o) && $stable(flags_o));
  // R12
  ready_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
  // R10
  ti_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> flags_o[F_I:F_T] == $past(flags_i[F_I:F_T]));
  // R11
  sign_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && op_i != 4'(OP_SWAP) |=> flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V]));
  // R4
  sticky_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && op_i == 4'(OP_SBC) && !flags_i[F_Z] |=> !flags_o[F_Z]);
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [3:0] op = 4'd0;
  logic [7:0] dst = 8'd0, src = 8'd0, hi = 8'd0, fl = 8'd0;
  logic [15:0] res;
  logic [7:0] flo;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  alu8_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .dst_i(dst), .src_i(src), .hi_i(hi), .flags_i(fl),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res), .flags_o(flo)
  );

  // bit order: C0 Z1 N2 V3 S4 H5 T6 I7
  function automatic logic [23:0] model(input logic [3:0] o, input logic [7:0] d,
                                        input logic [7:0] s, input logic [7:0] h,
                                        input logic [7:0] f);
    logic [7:0] r, v, x, g;
    logic [15:0] w, ow;
    g = f;
    r = d;
    w = 16'd0;
    case (o)
      4'd0, 4'd1: begin
        r = d + s + ((o == 4'd1) ? {7'd0, f[0]} : 8'd0);
        v = (d & s) | (s & ~r) | (~r & d);
        x = (d & s & ~r) | (~d & ~s & r);
        g[5] = v[3]; g[0] = v[7]; g[3] = x[7]; g[1] = (r == 0);
      end
      4'd2, 4'd3: begin
        r = d - s - ((o == 4'd3) ? {7'd0, f[0]} : 8'd0);
        v = (~d & s) | (s & r) | (r & ~d);
        x = (d & ~s & ~r) | (~d & s & r);
        g[5] = v[3]; g[0] = v[7]; g[3] = x[7];
        g[1] = (o == 4'd3) ? ((r != 0) ? 1'b0 : f[1]) : (r == 0);
      end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        r = (o == 4'd4) ? (d & s) : (o == 4'd5) ? (d | s) : (o == 4'd6) ? (d ^ s) : (8'hff - d);
        g[3] = 1'b0; g[1] = (r == 0);
        if (o == 4'd7) g[0] = 1'b1;
      end
      4'd8: begin
        r = 8'd0 - d;
        g[0] = (r != 0); g[3] = (r == 8'h80); g[5] = r[3] | d[3]; g[1] = (r == 0);
      end
      4'd9:  begin r = d + 8'd1; g[3] = (r == 8'h80); g[1] = (r == 0); end
      4'd10: begin r = d - 8'd1; g[3] = (r == 8'h7f); g[1] = (r == 0); end
      4'd11: r = {d[3:0], d[7:4]};
      4'd12, 4'd13, 4'd14: begin
        r = (o == 4'd12) ? {d[7], d[7:1]} : (o == 4'd13) ? {1'b0, d[7:1]} : {f[0], d[7:1]};
        g[0] = d[0]; g[1] = (r == 0); g[2] = r[7]; g[3] = r[7] ^ d[0];
      end
      default: begin
        ow = {h, d};
        if (s[6]) begin
          w = ow - {10'd0, s[5:0]};
          g[3] = ow[15] & ~w[15]; g[0] = w[15] & ~ow[15];
        end else begin
          w = ow + {10'd0, s[5:0]};
          g[3] = ~ow[15] & w[15]; g[0] = ~w[15] & ow[15];
        end
        g[1] = (w == 0); g[2] = w[15]; g[4] = g[2] ^ g[3];
      end
    endcase
    if (o != 4'd15) begin
      w = {8'd0, r};
      if (o != 4'd11) begin g[2] = r[7]; g[4] = g[2] ^ g[3]; end
    end
    return {w, g};
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11: return "R10";
      4'd15: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] d, input logic [7:0] s,
                     input logic [7:0] h, input logic [7:0] f);
    logic [23:0] e;
    @(negedge clk);
    op = o; dst = d; src = s; hi = h; fl = f; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    e = model(o, d, s, h, f);
    chk(req_of(o), {8'd0, res, flo}, {8'd0, e});
    // R11 S=N^V except SWAP; R10 T,I kept
    if (o != 4'd11) chk("R11", {31'd0, flo[4]}, {31'd0, flo[2] ^ flo[3]});
    chk("R10", {30'd0, flo[7:6]}, {30'd0, f[7:6]});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] ea, eb;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {12'd0, out_valid, in_ready, res}, {12'd0, 1'b0, 1'b1, 16'h0000});
    chk("R1", {24'd0, flo}, 32'd0);

    // directed corners
    run(4'd0, 8'h7f, 8'h01, 8'h00, 8'h00);   // R2 signed overflow, half carry
    run(4'd1, 8'hff, 8'h00, 8'h00, 8'h01);   // R2 carry in wraps to zero
    run(4'd2, 8'h10, 8'h01, 8'h00, 8'h00);   // R3 half borrow
    run(4'd3, 8'h05, 8'h04, 8'h00, 8'h01);   // R4 zero result, Z in = 0 stays 0
    run(4'd3, 8'h05, 8'h04, 8'h00, 8'h03);   // R4 zero result, Z in = 1 kept
    run(4'd3, 8'h00, 8'h00, 8'h00, 8'h03);   // R4 borrow through, Z cleared
    run(4'd7, 8'h00, 8'h00, 8'h00, 8'h28);   // R5 COM sets C, clears V
    run(4'd4, 8'hf0, 8'h0f, 8'h00, 8'h29);   // R5 AND zero, keeps C and H
    run(4'd8, 8'h80, 8'h00, 8'h00, 8'h00);   // R6 result 0x80
    run(4'd8, 8'h00, 8'h00, 8'h00, 8'h01);   // R6 zero result clears C
    run(4'd9, 8'h7f, 8'h00, 8'h00, 8'h21);   // R7 INC to 0x80, C/H kept
    run(4'd10, 8'h80, 8'h00, 8'h00, 8'h00);  // R7 DEC to 0x7F
    run(4'd14, 8'h01, 8'h00, 8'h00, 8'h01);  // R8 ROR old C to MSB
    run(4'd13, 8'h01, 8'h00, 8'h00, 8'h04);  // R8 LSR forces N=0
    run(4'd12, 8'h81, 8'h00, 8'h00, 8'h00);  // R8 ASR keeps sign
    run(4'd15, 8'hff, 8'h01, 8'hff, 8'h00);  // R9 word add wraps
    run(4'd15, 8'h00, 8'h41, 8'h00, 8'h00);  // R9 word sub borrow
    run(4'd15, 8'hff, 8'h01, 8'h7f, 8'h00);  // R9 word add overflow
    run(4'd11, 8'h3c, 8'h00, 8'h00, 8'hff);  // R10 SWAP keeps all flags

    // random
    for (int i = 0; i < 600; i++)
      run(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));

    // R12 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    op = 4'd0; dst = 8'h12; src = 8'h34; hi = 8'h00; fl = 8'h00; in_valid = 1'b1;
    ea = model(4'd0, 8'h12, 8'h34, 8'h00, 8'h00);
    @(posedge clk);
    #1 op = 4'd2; dst = 8'h50; src = 8'h60; fl = 8'h40;
    eb = model(4'd2, 8'h50, 8'h60, 8'h00, 8'h40);
    repeat (3) begin
      @(negedge clk);
      chk("R12", {15'd0, out_valid, in_ready, res}, {15'd0, 1'b1, 1'b0, ea[23:8]});
      chk("R12", {24'd0, flo}, {24'd0, ea[7:0]});
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12", {24'd0, in_ready, 7'd0}, {24'd0, 1'b1, 7'd0});
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R12", {8'd0, res, flo}, {8'd0, eb});
    @(negedge clk);
    chk("R12", {31'd0, out_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule